// File: doc/BRIEF.md
# Half-Duplex Debug Serial Port

This block is a single-wire asynchronous serial port for a debug monitor. One bidirectional data pin carries traffic in both directions, one direction at a time. The pin is shared through an output enable and an output value, and the pin's level comes back on an input. Bytes move as NRZ frames: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The same bit period applies in both directions.

The bit period is a whole number of bus clocks. A mode input chooses one of two divisors: one for an external oscillator (default 256) and one for the internal oscillator in forced monitor mode (default 335). The receiver samples at mid-bit and rechecks the start bit before it commits to a frame. A frame whose stop position is low is handled in one of two ways. If all its data bits are zero, it is a break, and the port answers with a fixed handshake: it drives the pin high for two bit periods, then sends a ten-bit-long low echo. Any other frame with a low stop position is reported as a framing error and dropped. While the port is transmitting or answering a break, the receiver ignores the line.

Top module: `mon_serial_port`

## Requirements
- R1: A transmitted frame is one low start bit, then tx_data bit 0 through bit 7 in that order, then one high stop bit. Each bit lasts one bit period, and the start bit begins on the clock edge that accepts the byte.
- R2: One bit period is DIV_EXT bus clocks when osc_int is 0 and DIV_INT bus clocks when osc_int is 1 (defaults 256 and 335). Receive and transmit use the same period.
- R3: A received frame with a high stop bit sets rx_valid, with the byte on rx_data (the first data bit on the line is bit 0). rx_valid stays high until a clock edge with rx_ready high clears it.
- R4: A low pulse on the line that ends before the middle of the start bit produces no rx_valid and no frame_err.
- R5: A received frame with a low stop bit and at least one data bit set raises frame_err for one clock. It sets no rx_valid and starts no break response.
- R6: A frame that is low for all ten bit positions is a break. Within one bit period after the break's tenth bit position begins, the port drives the pin high (pin_oe=1, pin_out=1) for exactly two bit periods.
- R7: Straight after the two-bit high hold, the port drives the pin low for exactly ten bit periods, then releases it (pin_oe=0).
- R8: After reset pin_oe=0, tx_ready=1 and rx_valid=0. pin_oe is 1 only while a frame is being sent or a break response is in progress.
- R9: tx_ready is 1 only when the port is idle. It drops on the edge that accepts a byte and stays low until the stop bit has finished.
- R10: While the port sends a frame or answers a break, the receiver ignores the line. The port's own transmission produces no rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_int | input | 1 | Divisor select: 0 picks DIV_EXT, 1 picks DIV_INT |
| pin_in | input | 1 | Level sensed on the data pin |
| pin_oe | output | 1 | Drive enable for the data pin |
| pin_out | output | 1 | Value driven when pin_oe is 1 |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_ready | input | 1 | Host takes the received byte |
| frame_err | output | 1 | One-clock pulse on a framing error |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Port accepts a byte this cycle |

## Verification
The bench sweeps all 256 byte values through the receiver and the transmitter, using small divisors and both divisor selections, and samples every bit at its expected mid-point. A port that takes the bits in the wrong order, or counts the wrong divisor, fails these checks. Breaks are timed from the start of the low line to the rise of the drive enable, and then through the hold and the echo bit by bit. A hold that is one bit short, or an echo that is mistimed or left driven, shows up there. A short low glitch, a frame with a low stop bit and nonzero data, and the quiet line after the port's own transmit or echo are each checked for a spurious byte or error pulse. Such a pulse would reveal a port that skips the start recheck, mistakes the error for a break, or decodes its own output.

// File: rtl/mon_serial_port.sv
module mon_serial_port #(
  parameter int DIV_EXT = 256,
  parameter int DIV_INT = 335
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_int,
  input  logic       pin_in,
  output logic       pin_oe,
  output logic       pin_out,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       frame_err,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready
);
  localparam int DIVMAX = (DIV_EXT > DIV_INT) ? DIV_EXT : DIV_INT;
  localparam int CW = $clog2(DIVMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_TX, S_HOLD, S_ECHO, S_WAIT} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [3:0]    bit_idx;
  logic [9:0]    shreg;
  logic [1:0]    sync;

  wire [CW-1:0] div_m1  = osc_int ? CW'(DIV_INT - 1) : CW'(DIV_EXT - 1);
  wire [CW-1:0] half_m1 = osc_int ? CW'(DIV_INT / 2 - 1) : CW'(DIV_EXT / 2 - 1);
  wire          rx_s    = sync[1];
  wire          tick    = (cnt == '0);

  assign pin_oe   = (state == S_TX) || (state == S_HOLD) || (state == S_ECHO);
  assign pin_out  = (state == S_TX) ? shreg[0] : (state == S_HOLD);
  assign tx_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '1;
      sync      <= 2'b11;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      sync      <= {sync[0], pin_in};
      frame_err <= 1'b0;
      if (rx_ready) rx_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          bit_idx <= '0;
          if (tx_valid) begin
            shreg <= {1'b1, tx_data, 1'b0};
            cnt   <= div_m1;
            state <= S_TX;
          end else if (!rx_s) begin
            cnt   <= half_m1;
            state <= S_RX;
          end
        end
        S_RX: begin
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            cnt     <= div_m1;
            bit_idx <= bit_idx + 4'd1;
            if (bit_idx == 4'd0) begin
              if (rx_s) state <= S_IDLE;
            end else if (bit_idx < 4'd9) begin
              shreg <= {rx_s, shreg[9:1]};
            end else if (rx_s) begin
              rx_data  <= shreg[9:2];
              rx_valid <= 1'b1;
              state    <= S_IDLE;
            end else if (shreg[9:2] == 8'h00) begin
              bit_idx <= '0;
              state   <= S_HOLD;
            end else begin
              frame_err <= 1'b1;
              state     <= S_WAIT;
            end
          end
        end
        S_TX: begin
          if (!tick) cnt <= cnt - 1'b1;
          else if (bit_idx == 4'd9) state <= S_IDLE;
          else begin
            bit_idx <= bit_idx + 4'd1;
            shreg   <= {1'b1, shreg[9:1]};
            cnt     <= div_m1;
          end
        end
        S_HOLD: begin
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            cnt <= div_m1;
            if (bit_idx == 4'd1) begin
              bit_idx <= '0;
              state   <= S_ECHO;
            end else bit_idx <= bit_idx + 4'd1;
          end
        end
        S_ECHO: begin
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            cnt <= div_m1;
            if (bit_idx == 4'd9) state <= S_IDLE;
            else bit_idx <= bit_idx + 4'd1;
          end
        end
        S_WAIT: if (rx_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_oe_excl_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> !tx_ready);
  assert_valid_from_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(state) == S_RX);
  assert_hold_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HOLD |-> pin_oe && pin_out);
  assert_hold_to_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_HOLD && state != S_HOLD) |-> state == S_ECHO);
  assert_err_no_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !$rose(rx_valid));
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_IDLE && state == S_TX) |-> !pin_out);
endmodule

// File: tb/mon_serial_port_tb_top.sv
module mon_serial_port_tb_top;
  localparam int DE = 8;
  localparam int DI = 11;

  logic clk = 0, rst_n = 0, osc_int = 0, host = 1, rx_ready = 0, tx_valid = 0;
  logic [7:0] tx_data = 0;
  logic pin_oe, pin_out, rx_valid, frame_err, tx_ready;
  logic [7:0] rx_data;
  wire pin_in = pin_oe ? pin_out : host;
  int n_chk = 0, n_bad = 0, ferr_cnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (frame_err) ferr_cnt++;

  mon_serial_port #(.DIV_EXT(DE), .DIV_INT(DI)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_int(osc_int), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .frame_err(frame_err), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bitp();
    return osc_int ? DI : DE;
  endfunction

  task automatic send_frame(input logic [7:0] b, input logic stop);
    int d = bitp();
    for (int i = 0; i < 10; i++) begin
      host = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
      repeat (d) @(negedge clk);
    end
    host = 1'b1;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    send_frame(b, 1'b1);
    check(rx_valid === 1'b1, "R3 valid", rx_valid, 1);
    check(rx_data === b, "R2/R3 data", rx_data, b);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid === 1'b0, "R3 clear", rx_valid, 0);
  endtask

  task automatic tx_byte(input logic [7:0] b);
    int d = bitp();
    logic [9:0] fr = {1'b1, b, 1'b0};
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready === 1'b0, "R9 drop", tx_ready, 0);
    repeat (d / 2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      check(pin_oe === 1'b1 && pin_out === fr[i], "R1/R2 tx bit", {pin_oe, pin_out}, {1'b1, fr[i]});
      if (i == 9) check(tx_ready === 1'b0, "R9 stop", tx_ready, 0);
      repeat (d) @(negedge clk);
    end
    check(tx_ready === 1'b1 && pin_oe === 1'b0, "R8/R9 release", {tx_ready, pin_oe}, 2);
    check(rx_valid === 1'b0, "R10 no self rx", rx_valid, 0);
  endtask

  task automatic do_break();
    int d = bitp();
    int n = 0;
    host = 1'b0;
    while (!pin_oe && n < 20 * d) begin
      @(negedge clk);
      n++;
    end
    host = 1'b1;
    check(n >= 9 * d && n <= 10 * d, "R6 detect time", n, 9 * d);
    repeat (d / 2) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      logic e = (i < 2);
      check(pin_oe === 1'b1 && pin_out === e, i < 2 ? "R6 hold" : "R7 echo", {pin_oe, pin_out}, {1'b1, e});
      repeat (d) @(negedge clk);
    end
    check(pin_oe === 1'b0, "R7 release", pin_oe, 0);
    repeat (3 * d) @(negedge clk);
    check(rx_valid === 1'b0 && tx_ready === 1'b1, "R10 echo ignored", {rx_valid, tx_ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pin_oe === 1'b0 && tx_ready === 1'b1 && rx_valid === 1'b0, "R8 reset",
          {pin_oe, tx_ready, rx_valid}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 256; v++) rx_byte(8'(v));
    osc_int = 1'b1;
    for (int v = 0; v < 256; v++) tx_byte(8'(v));
    for (int v = 0; v < 16; v++) rx_byte(8'(v * 17 + 3));
    osc_int = 1'b0;
    for (int v = 0; v < 16; v++) tx_byte(8'(v * 13 + 1));

    host = 1'b0;
    repeat (2) @(negedge clk);
    host = 1'b1;
    repeat (3 * DE) @(negedge clk);
    check(rx_valid === 1'b0 && ferr_cnt == 0 && tx_ready === 1'b1, "R4 glitch",
          {rx_valid, tx_ready}, 1);

    for (int m = 0; m < 2; m++) begin
      bit seen = 0;
      osc_int = m[0];
      ferr_cnt = 0;
      fork
        send_frame(8'h5A, 1'b0);
        while (host !== 1'b1 || !seen) begin
          @(negedge clk);
          if (pin_oe) seen = 1;
          if (host === 1'b1) break;
        end
      join
      repeat (bitp()) @(negedge clk);
      check(ferr_cnt == 1, "R5 err pulse", ferr_cnt, 1);
      check(rx_valid === 1'b0 && !seen && pin_oe === 1'b0, "R5 no byte/break",
            {rx_valid, seen, pin_oe}, 0);
      do_break();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule